// File: doc/BRIEF.md
# Waveform descriptor sequencer

This block is a small programmable engine that moves samples from an external 8-bit parallel bus into an internal FIFO. Its behaviour is not fixed in gates. A host first downloads a 128-byte descriptor memory, which holds four waveforms of eight states each. A start strobe then launches a FIFO-read transaction. The sequencer steps through the chosen waveform, interpreting the descriptor bytes of each state. State 7 is the idle state, and reaching it ends the transaction.

Each state has four descriptor bytes:

- **Segment byte.** In a plain state it gives a dwell length in clock cycles. In a decision state it gives the branch targets.
- **Opcode byte.** It marks the state as a decision point and/or as a sampling state.
- **Output byte.** It drives the control pins.
- **Logic byte.** It selects a two-input function over internal flags, one of which is the FIFO-full flag.

A typical program samples in state 0 and then decides in state 1. It returns to state 0 while the FIFO has room and goes idle once the FIFO is full.

While idle, the control pins show a programmable idle value. The data bus output enable is released when the idle-drive input is set. An abort input forces the sequencer to idle at any time.

Top module: `wfd_sequencer`

## Requirements
- R1: A descriptor byte written at address {waveform[1:0], group[1:0], state[2:0]} is used by that state of that waveform. The groups are: 0 segment, 1 opcode, 2 output, 3 logic.
- R2: After reset and whenever idle (state 7):
  - `done` is 1 and `fifo_we` is 0.
  - `ctl_out` equals `ctl_idle`.
  - `bus_oe` equals the inverse of `idle_drive`.
- R3: A `start_rd` pulse while idle and without abort enters state 0 on the next clock. The waveform is the one selected by `xact_map[1:0]`; bits [7:2] of `xact_map` have no effect on a FIFO read.
- R4: In a state with opcode bit 0 clear, the sequencer stays L cycles, where L is the segment byte (1 to 255) and 0 means 256 cycles. It then moves to the next state number, and leaving state 6 this way enters idle.
- R5: In every active cycle of a state with opcode bit 1 set, `fifo_we` is 1 and `fifo_wdata` equals `bus_in` in that same cycle.
- R6: In an active state, `ctl_out` equals bits [5:0] of that state's output byte.
- R7: A state with opcode bit 0 set evaluates its decision in one cycle. It then moves to segment bits [5:3] when the result is true, or to bits [2:0] when it is false.
- R8: The logic byte works as follows:
  - Bits [7:6] pick the function: 00 A AND B, 01 A OR B, 10 A XOR B, 11 A AND NOT B.
  - Bits [5:3] select input A and bits [2:0] select input B.
  - Input code 6 is the FIFO-full flag, code 7 is constant 1, and all other codes read 0.
- R9: When segment bit 7 is set and the chosen target equals the current decision state, that state re-evaluates on the following cycles without sampling. When bit 7 is clear, a self-target re-enters the state and samples again if its opcode asks for it.
- R10: `abort` sends the sequencer to idle on the next clock from any state, and it wins over a simultaneous start.
- R11: A `start_rd` pulse while not idle has no effect on the running waveform.
- R12: The two-state sample-then-test program writes one sample per two cycles while the FIFO has room. It reaches idle two clocks after the full flag is seen in the sampling state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| desc_we | input | 1 | Descriptor byte write enable |
| desc_addr | input | 7 | Descriptor byte address |
| desc_wdata | input | 8 | Descriptor byte data |
| xact_map | input | 8 | Transaction-to-waveform map; [1:0] used for FIFO read |
| start_rd | input | 1 | Start strobe for a FIFO-read transaction |
| abort | input | 1 | Force the sequencer to idle |
| bus_in | input | 8 | Sampled parallel data bus |
| fifo_full | input | 1 | FIFO-full flag |
| fifo_we | output | 1 | FIFO write strobe |
| fifo_wdata | output | 8 | FIFO write data |
| ctl_out | output | 6 | Control pin values |
| ctl_idle | input | 6 | Control pin value while idle |
| idle_drive | input | 1 | When set, the data bus is released while idle |
| bus_oe | output | 1 | Data bus output enable |
| done | output | 1 | Idle / transaction finished |

## Verification
The sample-then-test program is run with the full flag held low for several loops and then raised. This separates a correct branch polarity from an inverted one, and it pins down the exact sample count.

A second waveform is placed at a map position that differs from the other map fields. It chains the following:

- a three-cycle sampling state;
- a zero-length (256-cycle) state;
- an unconditional branch;
- a re-executing decision held by the full flag.

This run exposes errors in waveform selection, in dwell counting and in sampling during re-execution.

A self-targeting decision without the re-execute bit shows repeated sampling. A fourth waveform walks the OR, AND-NOT and XOR functions with a cleared flag. A start pulsed mid-run, and an abort issued together with a start, check that foreign strobes cannot disturb the run.

// File: rtl/wfd_pkg.sv
package wfd_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned ST_W    = 3;
  localparam int unsigned GRP_NUM = 4;

  localparam logic [ST_W-1:0] ST_IDLE = 3'd7;

  // Byte group inside one waveform
  localparam int unsigned GRP_SEG = 0;
  localparam int unsigned GRP_OP  = 1;
  localparam int unsigned GRP_OUT = 2;
  localparam int unsigned GRP_LF  = 3;

  typedef enum logic [1:0] {
    LF_AND  = 2'b00,
    LF_OR   = 2'b01,
    LF_XOR  = 2'b10,
    LF_ANDN = 2'b11
  } lf_op_e;

  typedef struct packed {
    lf_op_e          op;
    logic [ST_W-1:0] sel_a;
    logic [ST_W-1:0] sel_b;
  } lf_desc_t;

  typedef struct packed {
    logic            reexec;
    logic            spare;
    logic [ST_W-1:0] tgt_true;
    logic [ST_W-1:0] tgt_false;
  } br_desc_t;
endpackage

// File: rtl/wfd_desc_mem.sv
module wfd_desc_mem #(
  parameter int unsigned WF_NUM  = 4,
  parameter int unsigned ST_NUM  = 8,
  parameter int unsigned GRP_NUM = 4,
  parameter int unsigned DW      = 8,
  localparam int unsigned WF_W   = $clog2(WF_NUM),
  localparam int unsigned SW     = $clog2(ST_NUM),
  localparam int unsigned GW     = $clog2(GRP_NUM),
  localparam int unsigned AW     = WF_W + GW + SW,
  localparam int unsigned DEPTH  = WF_NUM * GRP_NUM * ST_NUM
) (
  input  logic                         clk,
  input  logic                         wr_en,
  input  logic [AW-1:0]                wr_addr,
  input  logic [DW-1:0]                wr_data,
  input  logic [WF_W-1:0]              rd_wf,
  input  logic [SW-1:0]                rd_st,
  output logic [GRP_NUM-1:0][DW-1:0]   rd_grp
);
  logic [DW-1:0] store_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      store_q[wr_addr] <= wr_data;
    end
  end

  // One combinational read per descriptor group of the current state
  for (genvar g = 0; g < GRP_NUM; g++) begin : g_rd
    localparam logic [GW-1:0] GIDX = GW'(g);
    assign rd_grp[g] = store_q[{rd_wf, GIDX, rd_st}];
  end
endmodule

// File: rtl/wfd_decide.sv
module wfd_decide
  import wfd_pkg::*;
#(
  parameter int unsigned FLAG_CODE = 6,
  parameter int unsigned ONE_CODE  = 7,
  localparam int unsigned SRC_NUM  = 2 ** ST_W
) (
  input  lf_desc_t lf,
  input  logic     fifo_flag,
  output logic     result
);
  logic [SRC_NUM-1:0] src;
  logic               in_a;
  logic               in_b;

  always_comb begin
    src            = '0;
    src[FLAG_CODE] = fifo_flag;
    src[ONE_CODE]  = 1'b1;
  end

  assign in_a = src[lf.sel_a];
  assign in_b = src[lf.sel_b];

  always_comb begin
    unique case (lf.op)
      LF_AND:  result = in_a & in_b;
      LF_OR:   result = in_a | in_b;
      LF_XOR:  result = in_a ^ in_b;
      default: result = in_a & ~in_b;
    endcase
  end
endmodule

// File: rtl/wfd_sequencer.sv
module wfd_sequencer
  import wfd_pkg::*;
#(
  parameter int unsigned WF_NUM  = 4,
  parameter int unsigned CTL_W   = 6,
  localparam int unsigned WF_W   = $clog2(WF_NUM),
  localparam int unsigned MAP_W  = 4 * WF_W,
  localparam int unsigned ST_NUM = 2 ** ST_W,
  localparam int unsigned AW     = WF_W + $clog2(GRP_NUM) + ST_W,
  localparam int unsigned CNT_W  = BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              desc_we,
  input  logic [AW-1:0]     desc_addr,
  input  logic [BYTE_W-1:0] desc_wdata,
  input  logic [MAP_W-1:0]  xact_map,
  input  logic              start_rd,
  input  logic              abort,
  input  logic [BYTE_W-1:0] bus_in,
  input  logic              fifo_full,
  output logic              fifo_we,
  output logic [BYTE_W-1:0] fifo_wdata,
  output logic [CTL_W-1:0]  ctl_out,
  input  logic [CTL_W-1:0]  ctl_idle,
  input  logic              idle_drive,
  output logic              bus_oe,
  output logic              done
);
  // Reset: asserted asynchronously, released on the clock
  logic rst_meta_q;
  logic srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      srst_n     <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      srst_n     <= rst_meta_q;
    end
  end

  logic [ST_W-1:0]  st_q,  st_d;
  logic [WF_W-1:0]  wf_q,  wf_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             rx_q,  rx_d;
  logic             seq_en;

  logic [GRP_NUM-1:0][BYTE_W-1:0] grp;
  logic [BYTE_W-1:0] seg_b;
  logic [BYTE_W-1:0] op_b;
  logic [BYTE_W-1:0] out_b;
  br_desc_t          br;
  lf_desc_t          lf;
  logic              is_idle;
  logic              is_dp;
  logic              seg_last;
  logic              dec;
  logic [ST_W-1:0]   tgt;

  wfd_desc_mem #(
    .WF_NUM (WF_NUM),
    .ST_NUM (ST_NUM),
    .GRP_NUM(GRP_NUM),
    .DW     (BYTE_W)
  ) i_mem (
    .clk    (clk),
    .wr_en  (desc_we),
    .wr_addr(desc_addr),
    .wr_data(desc_wdata),
    .rd_wf  (wf_q),
    .rd_st  (st_q),
    .rd_grp (grp)
  );

  assign seg_b = grp[GRP_SEG];
  assign op_b  = grp[GRP_OP];
  assign out_b = grp[GRP_OUT];
  assign br    = br_desc_t'(seg_b);
  assign lf    = lf_desc_t'(grp[GRP_LF]);

  wfd_decide i_dec (
    .lf       (lf),
    .fifo_flag(fifo_full),
    .result   (dec)
  );

  assign is_idle  = (st_q == ST_IDLE);
  assign is_dp    = op_b[0];
  assign seg_last = (cnt_q == (seg_b - 8'd1));   // 0 wraps to 256 cycles
  assign tgt      = dec ? br.tgt_true : br.tgt_false;

  // Next-state logic
  always_comb begin
    st_d  = st_q;
    wf_d  = wf_q;
    cnt_d = cnt_q;
    rx_d  = rx_q;
    if (abort) begin
      st_d  = ST_IDLE;
      cnt_d = '0;
      rx_d  = 1'b0;
    end else if (is_idle) begin
      if (start_rd) begin
        st_d  = '0;
        wf_d  = xact_map[WF_W-1:0];
        cnt_d = '0;
        rx_d  = 1'b0;
      end
    end else if (is_dp) begin
      st_d  = tgt;
      cnt_d = '0;
      rx_d  = br.reexec && (tgt == st_q);
    end else begin
      rx_d = 1'b0;
      if (seg_last) begin
        st_d  = st_q + 3'd1;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 8'd1;
      end
    end
  end

  assign seq_en = abort | start_rd | ~is_idle;

  // State registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st_q  <= ST_IDLE;
      wf_q  <= '0;
      cnt_q <= '0;
      rx_q  <= 1'b0;
    end else if (seq_en) begin
      st_q  <= st_d;
      wf_q  <= wf_d;
      cnt_q <= cnt_d;
      rx_q  <= rx_d;
    end
  end

  // Outputs
  assign done       = is_idle;
  assign fifo_we    = ~is_idle & op_b[1] & ~rx_q;
  assign fifo_wdata = bus_in;
  assign ctl_out    = is_idle ? ctl_idle : out_b[CTL_W-1:0];
  assign bus_oe     = is_idle & ~idle_drive;

  logic bits_unused;
  assign bits_unused = ^{xact_map[MAP_W-1:WF_W], op_b[BYTE_W-1:2],
                         out_b[BYTE_W-1:CTL_W], br.spare};
endmodule

// File: rtl/wfd_sequencer_chk.sv
module wfd_sequencer_chk (
  input logic clk,
  input logic srst_n,
  input logic abort,
  input logic start_rd,
  input logic done,
  input logic fifo_we,
  input logic bus_oe
);
  assert_abort_idles_R10: assert property (
    @(posedge clk) disable iff (!srst_n) abort |=> done)
    else $error("abort did not reach idle");

  assert_idle_waits_R3: assert property (
    @(posedge clk) disable iff (!srst_n) (done && !start_rd) |=> done)
    else $error("left idle without a start");

  assert_start_launch_R3: assert property (
    @(posedge clk) disable iff (!srst_n) (done && start_rd && !abort) |=> !done)
    else $error("start did not launch");

  assert_no_idle_write_R5: assert property (
    @(posedge clk) disable iff (!srst_n) fifo_we |-> !done)
    else $error("FIFO write while idle");

  assert_bus_release_R2: assert property (
    @(posedge clk) disable iff (!srst_n) bus_oe |-> done)
    else $error("bus driven while active");
endmodule

bind wfd_sequencer wfd_sequencer_chk i_chk (
  .clk     (clk),
  .srst_n  (srst_n),
  .abort   (abort),
  .start_rd(start_rd),
  .done    (done),
  .fifo_we (fifo_we),
  .bus_oe  (bus_oe)
);

// File: tb/test_wfd_sequencer.sv
`timescale 1ns/1ps
module test_wfd_sequencer;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       desc_we;
  logic [6:0] desc_addr;
  logic [7:0] desc_wdata;
  logic [7:0] xact_map;
  logic       start_rd;
  logic       abort;
  logic [7:0] bus_in;
  logic       fifo_full;
  logic       fifo_we;
  logic [7:0] fifo_wdata;
  logic [5:0] ctl_out;
  logic [5:0] ctl_idle;
  logic       idle_drive;
  logic       bus_oe;
  logic       done;

  int checks = 0;
  int errors = 0;
  int wr_cnt = 0;
  int mark_cnt = 0;
  logic [5:0] mark;

  // Bench copy of descriptor memory and reference state
  logic [7:0] bmem [128];
  int m_st = 7, m_wf = 0, m_cnt = 0, m_rx = 0;

  always #5 clk = ~clk;

  wfd_sequencer i_wfd_sequencer (
    .clk(clk), .rst_n(rst_n), .desc_we(desc_we), .desc_addr(desc_addr),
    .desc_wdata(desc_wdata), .xact_map(xact_map), .start_rd(start_rd),
    .abort(abort), .bus_in(bus_in), .fifo_full(fifo_full), .fifo_we(fifo_we),
    .fifo_wdata(fifo_wdata), .ctl_out(ctl_out), .ctl_idle(ctl_idle),
    .idle_drive(idle_drive), .bus_oe(bus_oe), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input int addr, input int data);
    desc_we    = 1'b1;
    desc_addr  = 7'(addr);
    desc_wdata = 8'(data);
    bmem[addr] = 8'(data);
    tick();
    desc_we = 1'b0;
  endtask

  function automatic int src_val(input int code);
    if (code == 6) return int'(fifo_full);
    if (code == 7) return 1;
    return 0;
  endfunction

  // Behavioural reference, advanced on every clock
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 7; m_wf = 0; m_cnt = 0; m_rx = 0;
    end else if (abort) begin
      m_st = 7; m_cnt = 0; m_rx = 0;
    end else if (m_st == 7) begin
      if (start_rd) begin
        m_wf = xact_map & 3; m_st = 0; m_cnt = 0; m_rx = 0;
      end
    end else begin
      int seg, op, lfb, a, b, r, t, len;
      seg = bmem[m_wf*32 + m_st];
      op  = bmem[m_wf*32 + 8 + m_st];
      lfb = bmem[m_wf*32 + 24 + m_st];
      if (op % 2 == 1) begin
        a = src_val((lfb / 8) % 8);
        b = src_val(lfb % 8);
        case (lfb / 64)
          0: r = a & b;
          1: r = a | b;
          2: r = a ^ b;
          default: r = a & (1 - b);
        endcase
        t = r ? (seg / 8) % 8 : seg % 8;
        m_rx = (seg >= 128 && t == m_st) ? 1 : 0;
        m_st = t; m_cnt = 0;
      end else begin
        len = (seg == 0) ? 256 : seg;
        m_rx = 0;
        if (m_cnt + 1 >= len) begin m_st = m_st + 1; m_cnt = 0; end
        else m_cnt = m_cnt + 1;
      end
    end
  end

  // Compare against the reference on every clock, away from the edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit e_done, e_we;
      int e_ctl, op;
      e_done = (m_st == 7);
      op     = bmem[m_wf*32 + 8 + m_st];
      e_we   = !e_done && ((op / 2) % 2 == 1) && (m_rx == 0);
      e_ctl  = e_done ? int'(ctl_idle) : bmem[m_wf*32 + 16 + m_st] % 64;
      chk(done == e_done, "R2 done", done, e_done);
      chk(bus_oe == (e_done && !idle_drive), "R2 bus_oe", bus_oe, e_done && !idle_drive);
      chk(int'(ctl_out) == e_ctl, "R6 ctl_out", ctl_out, e_ctl);
      chk(fifo_we == e_we, "R5 fifo_we", fifo_we, e_we);
      if (e_we) chk(fifo_wdata == bus_in, "R5 fifo_wdata", fifo_wdata, bus_in);
      if (fifo_we) wr_cnt++;
      if (!done && ctl_out == mark) mark_cnt++;
    end
  end

  initial begin
    bus_in = 8'h00;
    forever begin
      @(posedge clk);
      #1;
      bus_in = bus_in + 8'd13;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; desc_we = 1'b0; desc_addr = '0; desc_wdata = '0;
    xact_map = 8'hE4; start_rd = 1'b0; abort = 1'b0; fifo_full = 1'b0;
    ctl_idle = 6'h2D; idle_drive = 1'b1; mark = 6'h3F;
    for (int i = 0; i < 128; i++) bmem[i] = 8'h00;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();

    // R2: idle state after reset
    @(negedge clk);
    chk(done == 1'b1, "R2 reset done", done, 1);
    chk(ctl_out == 6'h2D, "R2 idle ctl", ctl_out, 6'h2D);
    chk(bus_oe == 1'b0, "R2 released bus", bus_oe, 0);
    chk(fifo_we == 1'b0, "R2 no write", fifo_we, 0);
    idle_drive = 1'b0;
    @(negedge clk);
    chk(bus_oe == 1'b1, "R2 driven bus", bus_oe, 1);
    idle_drive = 1'b1;

    for (int i = 0; i < 128; i++) wr(i, 0);
    // wf0: sample, then test FIFO full
    wr(0, 8'h01); wr(1, 8'h38); wr(8, 8'h02); wr(9, 8'h01);
    wr(16, 8'h15); wr(17, 8'h2A); wr(25, 8'h36);
    // wf1: self-targeting decision without re-execute
    wr(32, 8'h07); wr(40, 8'h03); wr(48, 8'h11); wr(56, 8'h36);
    // wf2: dwell, long dwell, branch, sample, re-executing decision
    wr(64, 3); wr(65, 0); wr(66, 8'h1F); wr(67, 1); wr(68, 8'hA7);
    wr(72, 2); wr(73, 0); wr(74, 1); wr(75, 2); wr(76, 3);
    wr(80, 1); wr(81, 8'h22); wr(82, 3); wr(83, 4); wr(84, 5);
    wr(90, 8'h3F); wr(92, 8'h37);
    // wf3: OR, AND-NOT, XOR decisions
    wr(96, 8'h39); wr(97, 8'h17); wr(98, 8'h3D); wr(101, 1); wr(102, 1);
    wr(104, 1); wr(105, 1); wr(106, 1);
    wr(112, 8'h31); wr(113, 8'h32); wr(114, 8'h33); wr(117, 8'h35); wr(118, 8'h36);
    wr(120, 8'h70); wr(121, 8'hFE); wr(122, 8'hBE);

    // R12 / R7: sample until full
    xact_map = 8'hE4; fifo_full = 1'b0; wr_cnt = 0;
    start_rd = 1'b1; tick(); start_rd = 1'b0;
    repeat (10) tick();
    fifo_full = 1'b1;
    repeat (2) tick();
    @(negedge clk);
    chk(done == 1'b1, "R12 idle after full", done, 1);
    chk(wr_cnt == 6, "R12 sample count", wr_cnt, 6);
    chk(wr_cnt == 6, "R7 branch polarity", wr_cnt, 6);

    // R1 / R3 / R4 / R9: waveform 2 through map bits [1:0]
    xact_map = 8'h1E; fifo_full = 1'b1; wr_cnt = 0; mark_cnt = 0; mark = 6'h22;
    start_rd = 1'b1; tick(); start_rd = 1'b0;
    @(negedge clk);
    chk(ctl_out == 6'h01, "R1 R3 waveform select", ctl_out, 6'h01);
    repeat (300) tick();
    @(negedge clk);
    chk(done == 1'b0, "R9 re-execute holds", done, 0);
    chk(wr_cnt == 5, "R9 no resample", wr_cnt, 5);
    chk(mark_cnt == 256, "R4 zero length", mark_cnt, 256);
    fifo_full = 1'b0;
    tick();
    @(negedge clk);
    chk(done == 1'b1, "R8 AND false exits", done, 1);

    // R9: self target without re-execute samples each pass
    xact_map = 8'h01; fifo_full = 1'b1; wr_cnt = 0;
    start_rd = 1'b1; tick(); start_rd = 1'b0;
    repeat (4) tick();
    fifo_full = 1'b0;
    tick();
    @(negedge clk);
    chk(done == 1'b1, "R9 loop exit", done, 1);
    chk(wr_cnt == 5, "R9 resample count", wr_cnt, 5);

    // R8: OR / AND-NOT / XOR
    xact_map = 8'h03; fifo_full = 1'b0;
    start_rd = 1'b1; tick(); start_rd = 1'b0;
    tick(); @(negedge clk);
    chk(ctl_out == 6'h32, "R8 OR false", ctl_out, 6'h32);
    tick(); @(negedge clk);
    chk(ctl_out == 6'h33, "R8 AND-NOT true", ctl_out, 6'h33);
    tick(); @(negedge clk);
    chk(done == 1'b1, "R8 XOR true", done, 1);
    fifo_full = 1'b1;
    start_rd = 1'b1; tick(); start_rd = 1'b0;
    tick(); @(negedge clk);
    chk(done == 1'b1, "R8 OR true", done, 1);

    // R11 / R10: foreign start and abort
    xact_map = 8'h1E; fifo_full = 1'b1;
    start_rd = 1'b1; tick(); start_rd = 1'b0;
    repeat (2) tick();
    start_rd = 1'b1; tick(); start_rd = 1'b0;
    @(negedge clk);
    chk(ctl_out == 6'h22, "R11 start ignored", ctl_out, 6'h22);
    abort = 1'b1; tick(); abort = 1'b0;
    @(negedge clk);
    chk(done == 1'b1, "R10 abort idles", done, 1);
    start_rd = 1'b1; abort = 1'b1; tick(); start_rd = 1'b0; abort = 1'b0;
    @(negedge clk);
    chk(done == 1'b1, "R10 abort beats start", done, 1);

    repeat (3) tick();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule